// File: doc/BRIEF.md
# Debug Event Status Capture

This block keeps the sticky record of debug events seen by a processor core. Event pulses from the trap, instruction-compare, data-compare, return, external-event, counter and critical-interrupt logic are gated by an ownership mask and by the two debug mode enables, and are latched into a 32-bit status word. Each status bit is owned either by software or by the hardware debugger. Whether an event may set its bit depends on that owner and on which debug mode is enabled.

Software clears bits by writing ones, and only bits it owns are affected. The external debug port can overwrite the whole word. Data-compare events are split into separate read and write bits, selected by a 2-bit mode code for each compare. A 2-bit offset field records the context of the last data-compare capture. A debug interrupt request is raised while software-owned status is pending and both the debug-enable and internal-mode bits are set.

Top module: `dbgstat_capture`

## Requirements
- R1: While `rst_n` is low, `status_o` is 0 and `dbg_irq` is 0.
- R2: A read pulse on data compare k (`dac_rd[k]`) may set status bit 8+2k only when that compare's mode code `dac_mode[2k+1:2k]` is 2'b10 or 2'b11.
- R3: A write pulse on data compare k (`dac_wr[k]`) may set status bit 9+2k only when the mode code is 2'b01 or 2'b11.
- R4: An event whose bit is software-owned (`own_sw[b]`=1) sets its bit only while `int_dbg_en`=1. A hardware-owned event sets its bit only while `ext_dbg_en`=1.
- R5: A software write (`sw_wr`) clears every bit b where `sw_wdata[b]`=1 and `own_sw[b]`=1. A written 1 on a hardware-owned bit leaves that bit unchanged.
- R6: When an event sets a bit in the same cycle that a software clear or port write hits it, the bit ends up set.
- R7: `dbg_irq` is 1 exactly when `msr_de`=1, `int_dbg_en`=1 and some status bit in {0, 3..19} is set and software-owned. Bits 1 (most recent reset), 2 (alternate-encoding status) and the offset field never raise it.
- R8: On a cycle that sets any data-compare bit (8..11) without a fault, the offset field (bits 21:20) becomes 2'b01 if `dac_dvc`=1 and 2'b00 otherwise. Without a data-compare capture, the field keeps its value apart from clears and port writes.
- R9: If `dac_fault`=1 on a data-compare capture, the offset field becomes 2'b00 and the imprecise bit (bit 0) is set, whoever owns bit 0.
- R10: Status layout: bit 3 trap, bits 4..7 instruction compares 1..4, bit 12 return, bits 13..14 external events, bits 15..16 counters, bit 17 critical interrupt, bit 18 critical return, and bit 19 counter-1 triggered (`ev_c1trg`). Each pulse sets its own bit.
- R11: Bits 31:22 always read 0, including after a port write of ones.
- R12: A port write (`port_wr`) replaces bits 21:0 with `port_wdata` regardless of ownership. It takes priority over a software write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_trap | input | 1 | Trap taken pulse |
| ev_iac | input | 4 | Instruction compare pulses |
| dac_rd | input | 2 | Read-type data compare pulses |
| dac_wr | input | 2 | Write-type data compare pulses |
| dac_mode | input | 4 | Mode code per data compare, 2 bits each |
| dac_dvc | input | 1 | Capture came from a data-value compare |
| dac_fault | input | 1 | Translation or storage error coincides with capture |
| ev_ret | input | 1 | Return pulse |
| ev_xev | input | 2 | External event pulses |
| ev_cnt | input | 2 | Debug counter pulses |
| ev_cirq | input | 1 | Critical interrupt taken pulse |
| ev_cret | input | 1 | Critical return pulse |
| ev_c1trg | input | 1 | Counter 1 triggered pulse |
| own_sw | input | 32 | Per-bit ownership, 1 = software |
| int_dbg_en | input | 1 | Internal debug mode enabled |
| ext_dbg_en | input | 1 | External debug mode enabled |
| msr_de | input | 1 | Machine-state debug enable |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data, 1 clears |
| port_wr | input | 1 | Debug port write strobe |
| port_wdata | input | 32 | Debug port write value |
| status_o | output | 32 | Status word |
| dbg_irq | output | 1 | Debug interrupt request |

## Verification
Every state bit of this block is visible on `status_o`, so any wrongly latched, missed or wrongly cleared bit shows on the port one clock edge after the cycle that caused it. A wrong gating decision can make the interrupt request differ in the same cycle as the status, because `dbg_irq` is decoded from the registered word without delay. A wrong offset-field decision shows at bits 21:20 on the edge after the data-compare capture. After that the value persists until something clears it, so the error stays visible.

// File: rtl/dbgstat_pkg.sv
package dbgstat_pkg;
  localparam int STAT_W = 32;
  localparam int IAC_N  = 4;
  localparam int DAC_N  = 2;
  localparam int XEV_N  = 2;
  localparam int CNT_N  = 2;
  localparam int OFS_W  = 2;

  localparam int B_IDE  = 0;
  localparam int B_MRR  = 1;
  localparam int B_VLE  = 2;
  localparam int B_TRAP = 3;
  localparam int B_IAC  = B_TRAP + 1;
  localparam int B_DAC  = B_IAC + IAC_N;
  localparam int B_RET  = B_DAC + 2 * DAC_N;
  localparam int B_XEV  = B_RET + 1;
  localparam int B_CNT  = B_XEV + XEV_N;
  localparam int B_CIRQ = B_CNT + CNT_N;
  localparam int B_CRET = B_CIRQ + 1;
  localparam int B_C1T  = B_CRET + 1;
  localparam int B_OFS  = B_C1T + 1;
  localparam int USED_W = B_OFS + OFS_W;

  function automatic logic [STAT_W-1:0] span_mask(input int lo, input int w);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[lo+i] = 1'b1;
    return m;
  endfunction

  localparam logic [STAT_W-1:0] USED_MASK = span_mask(0, USED_W);
  localparam logic [STAT_W-1:0] OFS_MASK  = span_mask(B_OFS, OFS_W);
  localparam logic [STAT_W-1:0] EV_MASK   = USED_MASK & ~OFS_MASK;
  localparam logic [STAT_W-1:0] IRQ_MASK  = EV_MASK & ~span_mask(B_MRR, 2);

  // mode bit 1 enables reads, mode bit 0 enables writes
  function automatic logic mode_allows(input logic [1:0] mode, input logic is_write);
    return is_write ? mode[0] : mode[1];
  endfunction

  function automatic logic [OFS_W-1:0] ofs_code(input logic fault, input logic dvc);
    return (fault || !dvc) ? OFS_W'(0) : OFS_W'(1);
  endfunction
endpackage

// File: rtl/dbgstat_qual.sv
module dbgstat_qual
  import dbgstat_pkg::*;
(
  input  logic                  ev_trap,
  input  logic [IAC_N-1:0]      ev_iac,
  input  logic [DAC_N-1:0]      dac_rd,
  input  logic [DAC_N-1:0]      dac_wr,
  input  logic [2*DAC_N-1:0]    dac_mode,
  input  logic                  dac_dvc,
  input  logic                  dac_fault,
  input  logic                  ev_ret,
  input  logic [XEV_N-1:0]      ev_xev,
  input  logic [CNT_N-1:0]      ev_cnt,
  input  logic                  ev_cirq,
  input  logic                  ev_cret,
  input  logic                  ev_c1trg,
  input  logic [STAT_W-1:0]     own_sw,
  input  logic                  int_dbg_en,
  input  logic                  ext_dbg_en,
  output logic [STAT_W-1:0]     set_vec,
  output logic                  dac_hit,
  output logic [OFS_W-1:0]      ofs_new
);
  logic [STAT_W-1:0] raw_ev;
  logic [STAT_W-1:0] allowed;
  logic [STAT_W-1:0] gated;

  assign raw_ev[B_IDE]  = 1'b0;
  assign raw_ev[B_MRR]  = 1'b0;
  assign raw_ev[B_VLE]  = 1'b0;
  assign raw_ev[B_TRAP] = ev_trap;
  assign raw_ev[B_IAC +: IAC_N] = ev_iac;
  for (genvar k = 0; k < DAC_N; k++) begin : g_dac
    assign raw_ev[B_DAC+2*k]   = dac_rd[k] && mode_allows(dac_mode[2*k +: 2], 1'b0);
    assign raw_ev[B_DAC+2*k+1] = dac_wr[k] && mode_allows(dac_mode[2*k +: 2], 1'b1);
  end
  assign raw_ev[B_RET]  = ev_ret;
  assign raw_ev[B_XEV +: XEV_N] = ev_xev;
  assign raw_ev[B_CNT +: CNT_N] = ev_cnt;
  assign raw_ev[B_CIRQ] = ev_cirq;
  assign raw_ev[B_CRET] = ev_cret;
  assign raw_ev[B_C1T]  = ev_c1trg;
  assign raw_ev[STAT_W-1:B_OFS] = '0;

  assign allowed = (own_sw & {STAT_W{int_dbg_en}}) | (~own_sw & {STAT_W{ext_dbg_en}});
  assign gated   = raw_ev & allowed & EV_MASK;
  assign dac_hit = |gated[B_DAC +: 2*DAC_N];
  assign ofs_new = ofs_code(dac_fault, dac_dvc);

  always_comb begin
    set_vec = gated;
    if (dac_hit && dac_fault) set_vec[B_IDE] = 1'b1;
  end
endmodule

// File: rtl/dbgstat_reg.sv
module dbgstat_reg
  import dbgstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              dac_hit,
  input  logic [OFS_W-1:0]  ofs_new,
  input  logic [STAT_W-1:0] own_sw,
  input  logic              sw_wr,
  input  logic [STAT_W-1:0] sw_wdata,
  input  logic              port_wr,
  input  logic [STAT_W-1:0] port_wdata,
  output logic [STAT_W-1:0] status_q
);
  logic [STAT_W-1:0] sw_clr;
  logic [STAT_W-1:0] base;
  logic [STAT_W-1:0] nxt;

  assign sw_clr = sw_wr ? (sw_wdata & own_sw) : '0;
  assign base   = port_wr ? port_wdata : (status_q & ~sw_clr);

  always_comb begin
    nxt = ((base | set_vec) & EV_MASK) | (base & OFS_MASK);
    if (dac_hit) nxt[B_OFS +: OFS_W] = ofs_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= nxt;
  end

  // R5: hardware-owned bits ignore software clears
  a_r5_hw_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !port_wr) |=>
      (((status_q ^ $past(status_q)) & ~$past(own_sw) & ~$past(set_vec) & EV_MASK) == '0));

  // R6: a set in the same cycle beats any clear or overwrite
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R11: reserved positions stay zero
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~USED_MASK) == '0);
endmodule

// File: rtl/dbgstat_irq.sv
module dbgstat_irq
  import dbgstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status_q,
  input  logic [STAT_W-1:0] own_sw,
  input  logic              msr_de,
  input  logic              int_dbg_en,
  output logic              sw_pending,
  output logic              irq
);
  assign sw_pending = |(status_q & own_sw & IRQ_MASK);
  assign irq        = sw_pending && msr_de && int_dbg_en;

  // R7: the request needs both enables
  a_r7_irq_enables: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (msr_de && int_dbg_en));
endmodule

// File: rtl/dbgstat_capture.sv
module dbgstat_capture
  import dbgstat_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_trap,
  input  logic [IAC_N-1:0]      ev_iac,
  input  logic [DAC_N-1:0]      dac_rd,
  input  logic [DAC_N-1:0]      dac_wr,
  input  logic [2*DAC_N-1:0]    dac_mode,
  input  logic                  dac_dvc,
  input  logic                  dac_fault,
  input  logic                  ev_ret,
  input  logic [XEV_N-1:0]      ev_xev,
  input  logic [CNT_N-1:0]      ev_cnt,
  input  logic                  ev_cirq,
  input  logic                  ev_cret,
  input  logic                  ev_c1trg,
  input  logic [STAT_W-1:0]     own_sw,
  input  logic                  int_dbg_en,
  input  logic                  ext_dbg_en,
  input  logic                  msr_de,
  input  logic                  sw_wr,
  input  logic [STAT_W-1:0]     sw_wdata,
  input  logic                  port_wr,
  input  logic [STAT_W-1:0]     port_wdata,
  output logic [STAT_W-1:0]     status_o,
  output logic                  dbg_irq
);
  logic [STAT_W-1:0] set_vec;
  logic              dac_hit;
  logic [OFS_W-1:0]  ofs_new;
  logic              sw_pending;

  dbgstat_qual u_qual (
    .ev_trap(ev_trap), .ev_iac(ev_iac), .dac_rd(dac_rd), .dac_wr(dac_wr),
    .dac_mode(dac_mode), .dac_dvc(dac_dvc), .dac_fault(dac_fault),
    .ev_ret(ev_ret), .ev_xev(ev_xev), .ev_cnt(ev_cnt), .ev_cirq(ev_cirq),
    .ev_cret(ev_cret), .ev_c1trg(ev_c1trg), .own_sw(own_sw),
    .int_dbg_en(int_dbg_en), .ext_dbg_en(ext_dbg_en),
    .set_vec(set_vec), .dac_hit(dac_hit), .ofs_new(ofs_new)
  );

  dbgstat_reg u_reg (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .dac_hit(dac_hit),
    .ofs_new(ofs_new), .own_sw(own_sw), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .port_wr(port_wr), .port_wdata(port_wdata), .status_q(status_o)
  );

  dbgstat_irq u_irq (
    .clk(clk), .rst_n(rst_n), .status_q(status_o), .own_sw(own_sw),
    .msr_de(msr_de), .int_dbg_en(int_dbg_en),
    .sw_pending(sw_pending), .irq(dbg_irq)
  );

  // R1: reset empties the word
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (status_o == '0));

  // R2, R3: data-compare bits rise only under a permitting mode code
  for (genvar k = 0; k < DAC_N; k++) begin : g_chk
    a_r2_rd_mode: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(status_o[B_DAC+2*k]) && !$past(port_wr)) |-> $past(dac_mode[2*k+1]));
    a_r3_wr_mode: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(status_o[B_DAC+2*k+1]) && !$past(port_wr)) |-> $past(dac_mode[2*k]));
  end

  // R4: trap bit rises only under the mode that matches its owner
  a_r4_owner_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status_o[B_TRAP]) && !$past(port_wr)) |->
      $past(own_sw[B_TRAP] ? int_dbg_en : ext_dbg_en));

  // R7: excluded bits alone never request
  a_r7_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o & IRQ_MASK) == '0) |-> !dbg_irq);

  // R8: clean value-compare capture loads offset 01
  a_r8_dvc_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_hit && !dac_fault && dac_dvc) |=> (status_o[B_OFS +: OFS_W] == OFS_W'(1)));

  // R9: faulted capture zeroes offset and flags imprecise
  a_r9_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_hit && dac_fault) |=> (status_o[B_IDE] && status_o[B_OFS +: OFS_W] == '0));
endmodule

// File: tb/sim_dbgstat_capture.sv
`timescale 1ns/1ps
module sim_dbgstat_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_trap = 0;
  logic [3:0]  ev_iac = 0;
  logic [1:0]  dac_rd = 0, dac_wr = 0;
  logic [3:0]  dac_mode = 0;
  logic        dac_dvc = 0, dac_fault = 0, ev_ret = 0;
  logic [1:0]  ev_xev = 0, ev_cnt = 0;
  logic        ev_cirq = 0, ev_cret = 0, ev_c1trg = 0;
  logic [31:0] own_sw = 0;
  logic        int_dbg_en = 0, ext_dbg_en = 0, msr_de = 0;
  logic        sw_wr = 0, port_wr = 0;
  logic [31:0] sw_wdata = 0, port_wdata = 0;
  logic [31:0] status_o;
  logic        dbg_irq;

  int    n_vec = 0, n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";
  logic [31:0] m_stat = 0;

  dbgstat_capture u0 (.*);

  always #4 clk = ~clk;

  function automatic bit m_irq();
    bit any = 0;
    for (int b = 0; b < 20; b++)
      if (b != 1 && b != 2 && m_stat[b] && own_sw[b]) any = 1;
    return any && msr_de && int_dbg_en;
  endfunction

  task automatic m_apply();
    logic [31:0] raw = 0, setb = 0, nxt;
    bit hit = 0;
    if (!rst_n) begin m_stat = 0; return; end
    raw[3] = ev_trap;
    for (int i = 0; i < 4; i++) raw[4+i] = ev_iac[i];
    for (int k = 0; k < 2; k++) begin
      int md = (dac_mode >> (2*k)) & 3;
      raw[8+2*k] = dac_rd[k] && (md == 2 || md == 3);
      raw[9+2*k] = dac_wr[k] && (md == 1 || md == 3);
    end
    raw[12] = ev_ret;
    for (int i = 0; i < 2; i++) begin raw[13+i] = ev_xev[i]; raw[15+i] = ev_cnt[i]; end
    raw[17] = ev_cirq; raw[18] = ev_cret; raw[19] = ev_c1trg;
    for (int b = 0; b < 32; b++)
      if (raw[b] && (own_sw[b] ? int_dbg_en : ext_dbg_en)) setb[b] = 1;
    for (int b = 8; b < 12; b++) if (setb[b]) hit = 1;
    if (hit && dac_fault) setb[0] = 1;
    nxt = port_wr ? port_wdata : m_stat;
    if (!port_wr && sw_wr)
      for (int b = 0; b < 32; b++) if (sw_wdata[b] && own_sw[b]) nxt[b] = 0;
    nxt = nxt | setb;
    if (hit) nxt[21:20] = dac_fault ? 2'd0 : (dac_dvc ? 2'd1 : 2'd0);
    nxt[31:22] = 0;
    m_stat = nxt;
  endtask

  task automatic tick();
    @(posedge clk);
    m_apply();
    @(negedge clk);
    n_vec++;
    if (status_o !== m_stat || dbg_irq !== m_irq()) begin
      n_bad++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               cur_req, status_o, dbg_irq, m_stat, m_irq());
    end
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet();
    ev_trap = 0; ev_iac = 0; dac_rd = 0; dac_wr = 0; ev_ret = 0; ev_xev = 0;
    ev_cnt = 0; ev_cirq = 0; ev_cret = 0; ev_c1trg = 0; sw_wr = 0; port_wr = 0;
    dac_fault = 0; dac_dvc = 0;
  endtask

  task automatic pwrite(input logic [31:0] v);
    port_wr = 1; port_wdata = v; tick(); port_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    repeat (3) tick();
    chk(status_o, 32'h0, "R1 status in reset");
    chk({31'b0, dbg_irq}, 32'h0, "R1 irq in reset");
    @(negedge clk); rst_n = 1;
    int_dbg_en = 1; ext_dbg_en = 1; own_sw = 32'hFFFF_FFFF;

    // R2 R3: each mode code, read and write pulse on both compares
    for (int md = 0; md < 4; md++) begin
      cur_req = "R2/R3";
      dac_mode = {md[1:0], md[1:0]}; dac_rd = 2'b11; dac_wr = 2'b11; tick(); quiet();
      chk({30'b0, status_o[8], status_o[10]}, {30'b0, md[1], md[1]}, "R2 read bit vs mode");
      chk({30'b0, status_o[9], status_o[11]}, {30'b0, md[0], md[0]}, "R3 write bit vs mode");
      pwrite(0);
    end

    // R4: ownership against mode enables
    cur_req = "R4";
    own_sw = 32'h0000_0008; int_dbg_en = 0; ext_dbg_en = 1;
    ev_trap = 1; ev_ret = 1; tick(); quiet();
    chk(status_o, 32'h0000_1000, "R4 sw trap blocked, hw return set");
    own_sw = 32'h0000_0008; int_dbg_en = 1; ext_dbg_en = 0;
    ev_trap = 1; ev_cirq = 1; tick(); quiet();
    chk(status_o, 32'h0000_1008, "R4 sw trap set, hw crit blocked");

    // R5: clear only software-owned bits
    cur_req = "R5";
    own_sw = 32'h0000_000F; int_dbg_en = 1; ext_dbg_en = 1;
    pwrite(32'h0000_00F8);
    sw_wr = 1; sw_wdata = 32'hFFFF_FFFF; tick(); quiet();
    chk(status_o, 32'h0000_00F0, "R5 hw bits kept, sw bit cleared");

    // R6: set wins over clear
    cur_req = "R6";
    own_sw = 32'hFFFF_FFFF;
    sw_wr = 1; sw_wdata = 32'h0000_00F0; ev_iac = 4'b0001; tick(); quiet();
    chk(status_o, 32'h0000_0010, "R6 set beats clear");
    port_wr = 1; port_wdata = 0; ev_c1trg = 1; tick(); quiet();
    chk(status_o, 32'h0008_0000, "R6 set beats port write");

    // R8 R9: offset field
    cur_req = "R8";
    pwrite(0);
    dac_mode = 4'b0011; dac_wr = 2'b01; dac_dvc = 1; tick(); quiet();
    chk(status_o, 32'h0010_0200, "R8 value compare offset 01");
    ev_ret = 1; tick(); quiet();
    chk({30'b0, status_o[21:20]}, 32'h1, "R8 offset held without capture");
    dac_rd = 2'b01; dac_dvc = 0; tick(); quiet();
    chk({30'b0, status_o[21:20]}, 32'h0, "R8 plain compare offset 00");
    cur_req = "R9";
    pwrite(32'h0020_0000);
    own_sw = 32'hFFFF_FFFE; ext_dbg_en = 0;
    dac_rd = 2'b01; dac_dvc = 1; dac_fault = 1; tick(); quiet();
    chk(status_o, 32'h0000_0101, "R9 fault zeroes offset sets imprecise");

    // R7: interrupt request
    cur_req = "R7"; own_sw = 32'hFFFF_FFFF; ext_dbg_en = 1;
    pwrite(32'h0000_0006); msr_de = 1; tick();
    chk({31'b0, dbg_irq}, 0, "R7 excluded bits do not request");
    pwrite(32'h0004_0000);
    chk({31'b0, dbg_irq}, 1, "R7 sw pending requests");
    own_sw = 32'h0; tick();
    chk({31'b0, dbg_irq}, 0, "R7 hw-owned does not request");
    own_sw = 32'hFFFF_FFFF; msr_de = 0; tick();
    chk({31'b0, dbg_irq}, 0, "R7 needs msr_de");
    msr_de = 1; int_dbg_en = 0; tick();
    chk({31'b0, dbg_irq}, 0, "R7 needs internal mode");
    int_dbg_en = 1;

    // R10: each plain event lands on its own bit
    cur_req = "R10"; pwrite(0);
    ev_iac = 4'b1000; ev_xev = 2'b10; ev_cnt = 2'b01; ev_cret = 1; ev_c1trg = 1; tick(); quiet();
    chk(status_o, 32'h000C_C080, "R10 event positions");

    // R11 R12: port overwrite and reserved
    cur_req = "R12";
    own_sw = 32'h0;
    port_wr = 1; port_wdata = 32'hFFFF_FFFF; sw_wr = 1; sw_wdata = 32'hFFFF_FFFF; tick(); quiet();
    chk(status_o, 32'h003F_FFFF, "R11 reserved zero, R12 port write wins");
    port_wr = 1; port_wdata = 32'h0000_0003; tick(); quiet();
    chk(status_o, 32'h0000_0003, "R12 port replaces hw-owned bits");

    // mixed traffic against the model
    cur_req = "random";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      ev_trap = r[0] & r[1]; ev_iac = $urandom & $urandom; dac_rd = r[3:2] & r[5:4];
      dac_wr = r[7:6] & r[9:8]; dac_mode = r[13:10]; dac_dvc = r[14]; dac_fault = r[15] & r[16];
      ev_ret = r[17] & r[18]; ev_xev = r[20:19] & r[22:21]; ev_cnt = r[24:23] & r[26:25];
      ev_cirq = r[27] & r[28]; ev_cret = r[29] & r[30]; ev_c1trg = r[31] & r[0];
      if ((i % 16) == 0) begin own_sw = $urandom; int_dbg_en = $urandom; ext_dbg_en = $urandom; msr_de = $urandom; end
      sw_wr = ($urandom % 5) == 0; sw_wdata = $urandom;
      port_wr = ($urandom % 23) == 0; port_wdata = $urandom;
      tick();
    end
    quiet();
    finish_run();
  end
endmodule